// File: doc/BRIEF.md
# Keypad Matrix Scanner and Encoder

This block scans a matrix of single-pole switches arranged as four columns by four or five rows and turns one closure into a binary key number. It enables exactly one column at a time to pull low. It watches the row lines, which sit high when idle. When a row reads low, the block stops the scan on that column and ignores every other row. It then waits for the closure to stay steady for a set number of scan ticks before it accepts the key.

An accepted key is stored in a code register and a data-valid flag rises. The flag drops on the first tick that sees the key released. The next key, even one already held down, is taken only after the release has also been steady for the debounce period. The code register keeps its value after release. It drives the code bus only while the active-low output enable is low, and the bus floats otherwise.

Scanning and debounce counting advance only on a one-cycle scan tick. The ticks must be at least three clock cycles apart, so that the two-stage row synchronizer settles after each column change.

Top module: `keypad_encoder`

## Requirements
- R1: Exactly one bit of `col_drive_o` is high at any time. With no key closed, the driven column steps 0, 1, 2, 3, 0 and so on, advancing once per `scan_tick`.
- R2: When a tick sees a low synchronized row, the driven column stops advancing. It stays where it is until the release debounce of that key has finished.
- R3: If the locked row reads high on a tick before the press debounce completes, the key is not accepted, `key_valid_o` stays low and scanning resumes.
- R4: When the locked row reads low on DEBOUNCE further consecutive ticks after the detecting tick, the code is latched and `key_valid_o` rises.
- R5: The code equals row × 4 + column, counted from zero, with bit 0 the LSB. Row 4 keys (codes 16 to 19) therefore set bit 4, clear bits 3 and 2, and carry the column in bits 1:0. A 4-row build has a 4-bit code and a 5-row build has a 5-bit code.
- R6: `key_valid_o` falls on the first tick that sees the locked row high, even if another key is held. Any other key is ignored while one is locked. It is accepted only after DEBOUNCE consecutive high ticks of the released row.
- R7: The code register changes only when a new key is accepted, and keeps the last code after release.
- R8: `key_code_o` is high-impedance whenever `out_en_n` is 1, and shows the code register when it is 0.
- R9: With DEBOUNCE = 0, a key is accepted on the same tick that first sees its row low.
- R10: If several rows read low in the driven column on the detecting tick, the lowest-numbered row is taken.
- R11: Synchronous reset drives column 0, clears `key_valid_o` and the code register, and restarts scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle strobe that advances scanning and debounce |
| row_n_i | input | NUM_ROWS | Row lines, active low, idle high |
| col_drive_o | output | 4 | One-hot column pull-low enables |
| out_en_n | input | 1 | Active-low enable of the code bus |
| key_code_o | output | CODE_W | Key code bus, high-impedance when disabled |
| key_valid_o | output | 1 | Data-valid flag |

## Verification
Two events can fall on the same tick: a release that drops the valid flag, and a second key already closed that is waiting for acceptance. The bench holds one key, then closes a second key in another column. It releases the first key while the second is still down. It then judges that the flag falls on the release tick, that the code does not move, and that the second key arrives only after a full release debounce and a fresh press debounce. A behavioural model stepped every clock predicts the column, flag and bus values throughout. A press bounce shorter than the debounce period is also played against the model.

// File: rtl/kpenc_pkg.sv
package kpenc_pkg;

    localparam int NUM_COLS  = 4;
    localparam int COL_W     = 2;
    localparam int MAX_ROWS  = 8;
    localparam int ROW_IDX_W = 3;

    typedef enum logic [1:0] {
        ST_SCAN,
        ST_PRESS,
        ST_HELD,
        ST_RELEASE
    } kp_state_e;

    typedef struct packed {
        logic [ROW_IDX_W-1:0] row;
        logic [COL_W-1:0]     col;
    } kp_pos_t;

    // lowest set bit of a low-row mask
    function automatic logic [ROW_IDX_W-1:0] first_low(input logic [MAX_ROWS-1:0] low);
        logic [ROW_IDX_W-1:0] idx;
        idx = '0;
        for (int i = MAX_ROWS - 1; i >= 0; i--) begin
            if (low[i]) idx = ROW_IDX_W'(i);
        end
        return idx;
    endfunction

    // row * 4 + column
    function automatic logic [ROW_IDX_W+COL_W-1:0] key_index(input kp_pos_t p);
        return {p.row, p.col};
    endfunction

endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            sync_o <= '1;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/kp_col_scan.sv
module kp_col_scan
    import kpenc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    output logic [COL_W-1:0]    col_idx,
    output logic [NUM_COLS-1:0] col_drive
);
    always_ff @(posedge clk) begin
        if (rst) col_idx <= '0;
        else if (advance) col_idx <= col_idx + 1'b1;
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_dec
        assign col_drive[c] = (col_idx == COL_W'(c));
    end

    // R1
    one_col_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(col_drive) == 1);

    // R2
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(col_drive));
endmodule

// File: rtl/kp_key_fsm.sv
module kp_key_fsm
    import kpenc_pkg::*;
#(
    parameter int NUM_ROWS = 5,
    parameter int DEBOUNCE = 3,
    parameter int CODE_W   = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [NUM_ROWS-1:0] rows_n,
    input  logic [COL_W-1:0]    col_idx,
    output logic                advance,
    output logic [CODE_W-1:0]   key_code,
    output logic                key_valid
);
    localparam int CNT_W = (DEBOUNCE > 1) ? $clog2(DEBOUNCE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((DEBOUNCE > 0) ? DEBOUNCE - 1 : 0);

    kp_state_e         state, state_nxt;
    kp_pos_t           lock, lock_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [CODE_W-1:0] code_nxt;
    logic              valid_nxt;

    logic [MAX_ROWS-1:0] rows8;
    logic [MAX_ROWS-1:0] low8;
    logic                any_low;
    logic                lock_high;
    kp_pos_t             found;

    always_comb begin
        rows8 = '1;
        rows8[NUM_ROWS-1:0] = rows_n;
        low8      = ~rows8;
        any_low   = |low8;
        lock_high = rows8[lock.row];
        found.row = first_low(low8);
        found.col = col_idx;
    end

    assign advance = tick && (state == ST_SCAN) && !any_low;

    always_comb begin
        state_nxt = state;
        lock_nxt  = lock;
        cnt_nxt   = cnt;
        code_nxt  = key_code;
        valid_nxt = key_valid;
        if (tick) begin
            unique case (state)
                ST_SCAN: begin
                    if (any_low) begin
                        lock_nxt = found;
                        cnt_nxt  = '0;
                        if (DEBOUNCE == 0) begin
                            code_nxt  = CODE_W'(key_index(found));
                            valid_nxt = 1'b1;
                            state_nxt = ST_HELD;
                        end else begin
                            state_nxt = ST_PRESS;
                        end
                    end
                end
                ST_PRESS: begin
                    if (lock_high) begin
                        state_nxt = ST_SCAN;
                    end else if (cnt == CNT_LAST) begin
                        code_nxt  = CODE_W'(key_index(lock));
                        valid_nxt = 1'b1;
                        state_nxt = ST_HELD;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (lock_high) begin
                        valid_nxt = 1'b0;
                        cnt_nxt   = '0;
                        state_nxt = (DEBOUNCE == 0) ? ST_SCAN : ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (!lock_high) cnt_nxt = '0;
                    else if (cnt == CNT_LAST) state_nxt = ST_SCAN;
                    else cnt_nxt = cnt + 1'b1;
                end
                default: state_nxt = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SCAN;
            lock      <= '0;
            cnt       <= '0;
            key_code  <= '0;
            key_valid <= 1'b0;
        end else begin
            state     <= state_nxt;
            lock      <= lock_nxt;
            cnt       <= cnt_nxt;
            key_code  <= code_nxt;
            key_valid <= valid_nxt;
        end
    end

    // R4
    valid_rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> $past(tick));

    // R6
    valid_fall_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(key_valid) |-> ($past(tick) && $past(lock_high)));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(key_valid) |-> $stable(key_code));

    // R3
    bounce_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRESS && tick && lock_high) |=> (state == ST_SCAN && !key_valid));
endmodule

// File: rtl/keypad_encoder.sv
module keypad_encoder
    import kpenc_pkg::*;
#(
    parameter  int NUM_ROWS = 5,
    parameter  int DEBOUNCE = 3,
    localparam int CODE_W   = (NUM_ROWS > 4) ? 5 : 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_tick,
    input  logic [NUM_ROWS-1:0] row_n_i,
    output logic [3:0]          col_drive_o,
    input  logic                out_en_n,
    output logic [CODE_W-1:0]   key_code_o,
    output logic                key_valid_o
);
    logic [NUM_ROWS-1:0] rows_sync;
    logic [COL_W-1:0]    col_idx;
    logic                advance;
    logic [CODE_W-1:0]   code_q;

    kp_row_sync #(.WIDTH(NUM_ROWS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (row_n_i),
        .sync_o  (rows_sync)
    );

    kp_col_scan u_scan (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .col_idx   (col_idx),
        .col_drive (col_drive_o)
    );

    kp_key_fsm #(
        .NUM_ROWS (NUM_ROWS),
        .DEBOUNCE (DEBOUNCE),
        .CODE_W   (CODE_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (scan_tick),
        .rows_n    (rows_sync),
        .col_idx   (col_idx),
        .advance   (advance),
        .key_code  (code_q),
        .key_valid (key_valid_o)
    );

    assign key_code_o = out_en_n ? {CODE_W{1'bz}} : code_q;
endmodule

// File: tb/tb_keypad_encoder.sv
module tb_keypad_encoder;
    localparam int ROWS = 5;
    localparam int DB   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_tick = 1'b0;
    logic       out_en_n = 1'b0;
    logic [4:0] row_n;
    logic [3:0] col_drive;
    wire  [4:0] key_code;
    logic       key_valid;
    logic [3:0] row_nb;
    logic [3:0] col_nb;
    wire  [3:0] code_nb;
    logic       valid_nb;
    logic [3:0] kd [5];

    int checks = 0, failures = 0, cycle = 0;
    bit done = 0;

    always #5 clk = ~clk;

    keypad_encoder #(.NUM_ROWS(ROWS), .DEBOUNCE(DB)) dut (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .row_n_i(row_n),
        .col_drive_o(col_drive), .out_en_n(out_en_n),
        .key_code_o(key_code), .key_valid_o(key_valid));

    keypad_encoder #(.NUM_ROWS(4), .DEBOUNCE(0)) dut_nodb (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .row_n_i(row_nb),
        .col_drive_o(col_nb), .out_en_n(1'b0),
        .key_code_o(code_nb), .key_valid_o(valid_nb));

    // switch matrix
    always_comb begin
        for (int r = 0; r < 5; r++) row_n[r] = ~|(kd[r] & col_drive);
        for (int r = 0; r < 4; r++) row_nb[r] = ~|(kd[r] & col_nb);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_state = 0, m_col = 0, m_row = 0, m_cnt = 0, m_dav = 0, m_code = 0;
    int m_s1 = 31, m_s2 = 31;
    always @(posedge clk) begin
        int raw;
        raw = 0;
        for (int r = 0; r < ROWS; r++) if (!kd[r][m_col]) raw |= (1 << r);
        if (rst) begin
            m_state = 0; m_col = 0; m_row = 0; m_cnt = 0; m_dav = 0; m_code = 0;
            m_s1 = 31; m_s2 = 31;
        end else begin
            if (scan_tick) begin
                if (m_state == 0) begin
                    if ((~m_s2 & 31) != 0) begin
                        for (int r = ROWS - 1; r >= 0; r--) if (!m_s2[r]) m_row = r;
                        m_cnt = 0;
                        m_state = 1;
                    end else m_col = (m_col + 1) % 4;
                end else if (m_state == 1) begin
                    if (m_s2[m_row]) m_state = 0;
                    else if (m_cnt == DB - 1) begin
                        m_code = m_row * 4 + m_col; m_dav = 1; m_state = 2;
                    end else m_cnt++;
                end else if (m_state == 2) begin
                    if (m_s2[m_row]) begin m_dav = 0; m_cnt = 0; m_state = 3; end
                end else begin
                    if (!m_s2[m_row]) m_cnt = 0;
                    else if (m_cnt == DB - 1) m_state = 0;
                    else m_cnt++;
                end
            end
            m_s2 = m_s1;
            m_s1 = raw;
        end
    end

    // tick generator and per-clock comparison
    int tphase = 0;
    int nb_rise = -1, main_rise = -1;
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(col_drive == 4'(1 << m_col), "R1/R2 column", col_drive, 1 << m_col);
            check(key_valid == m_dav[0], "R4/R6 valid", key_valid, m_dav);
            if (!out_en_n) check(key_code === 5'(m_code), "R5/R7 code", key_code, m_code);
            else check(key_code === 5'bzzzzz, "R8 bus float", key_code, 0);
            if (valid_nb && nb_rise < 0) nb_rise = cycle;
            if (key_valid && main_rise < 0) main_rise = cycle;
        end
        scan_tick <= (tphase == 3) && !rst;
        tphase = (tphase + 1) % 4;
    end

    always @(posedge clk) begin
        cycle++;
        if (cycle > 50000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycle);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask
    task automatic press(input int r, input int c);
        @(negedge clk); kd[r][c] = 1'b1;
    endtask
    task automatic lift(input int r, input int c);
        @(negedge clk); kd[r][c] = 1'b0;
    endtask

    initial begin
        for (int r = 0; r < 5; r++) kd[r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(col_drive == 4'b0001, "R11 reset column", col_drive, 1);
        check(key_valid == 1'b0, "R11 reset valid", key_valid, 0);
        check(key_code === 5'd0, "R11 reset code", key_code, 0);
        wait_ticks(10);

        // R4 R5 R9: single key row 1 column 2
        nb_rise = -1; main_rise = -1;
        press(1, 2);
        wait_ticks(12);
        check(key_valid == 1'b1, "R4 accepted", key_valid, 1);
        check(key_code === 5'd6, "R5 code row1 col2", key_code, 6);
        check(code_nb === 4'd6, "R9 nodebounce code", code_nb, 6);
        check(nb_rise >= 0 && nb_rise < main_rise, "R9 nodebounce earlier", nb_rise, main_rise);
        lift(1, 2);
        wait_ticks(8);
        check(key_valid == 1'b0, "R6 released", key_valid, 0);
        check(key_code === 5'd6, "R7 code kept", key_code, 6);
        check(valid_nb == 1'b0, "R9 nodebounce released", valid_nb, 0);

        // R3 bounce on row 2 column 3
        for (int i = 0; i < 3; i++) begin
            press(2, 3); repeat (6) @(negedge clk);
            lift(2, 3); repeat (5) @(negedge clk);
        end
        check(key_valid == 1'b0, "R3 bounce rejected", key_valid, 0);
        press(2, 3);
        wait_ticks(12);
        check(key_code === 5'd11, "R3 code after bounce", key_code, 11);
        lift(2, 3);
        wait_ticks(8);

        // R6 roll-over: hold row0 col1, add row3 col0, release first
        press(0, 1);
        wait_ticks(10);
        press(3, 0);
        wait_ticks(6);
        check(key_valid == 1'b1 && key_code === 5'd1, "R6 lockout keeps first", key_code, 1);
        check(col_drive == 4'b0010, "R2 column frozen", col_drive, 2);
        lift(0, 1);
        wait_ticks(2);
        check(key_valid == 1'b0, "R6 valid drops on release", key_valid, 0);
        check(key_code === 5'd1, "R7 code holds during rollover", key_code, 1);
        wait_ticks(16);
        check(key_valid == 1'b1 && key_code === 5'd12, "R6 second key accepted", key_code, 12);
        lift(3, 0);
        wait_ticks(8);

        // R10 two rows in one column
        @(negedge clk); kd[1][0] = 1'b1; kd[3][0] = 1'b1;
        wait_ticks(12);
        check(key_code === 5'd4, "R10 lowest row wins", key_code, 4);
        @(negedge clk); kd[1][0] = 1'b0; kd[3][0] = 1'b0;
        wait_ticks(8);

        // R5 fifth row, R8 output enable
        press(4, 3);
        wait_ticks(12);
        check(key_code === 5'd19, "R5 fifth row code", key_code, 19);
        @(negedge clk); out_en_n = 1'b1;
        @(negedge clk);
        check(key_code === 5'bzzzzz, "R8 floats when disabled", key_code, 0);
        out_en_n = 1'b0;
        @(negedge clk);
        check(key_code === 5'd19, "R8 drives when enabled", key_code, 19);
        lift(4, 3);
        wait_ticks(8);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule